// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-port memory. It watches the enable and address lines of a left port and a right port and notices when both ports are enabled on the same word at once. In that case one port keeps access and the other is told to wait through a busy flag. The port that held a valid enable and address first keeps the word. If the addresses already match, the later enable triggers the decision. If both enables are already on, the later address change triggers it. When both ports arrive in the same cycle, the left port wins. The decision is stored and kept until the addresses stop matching.

A mode input selects whether this block drives the busy flags itself or takes them as inputs from a companion arbiter. In driving mode, the losing port's write strobe to the memory is suppressed while its busy flag is up. In receiving mode, an asserted incoming busy flag suppresses that port's write strobe. Reads are never gated. The busy outputs and write strobes are combinational from the inputs and the stored owner, so they follow the inputs in the same cycle.

Top module: `dp_collision_arbiter`

## Requirements
- R1: A busy output is 1 only when both enables are 1 and the two addresses are equal.
- R2: With equal addresses, when one port's enable is already 1 and the other port's enable rises, the port whose enable rose gets busy in that same cycle.
- R3: With both enables at 1, when one port's address changes to equal the other's, the port whose address changed gets busy in that same cycle.
- R4: When both ports become valid on the same address in the same cycle, exactly one busy output is 1, and it is busyOutR (the left port wins).
- R5: A busy output falls in the same cycle that the addresses stop matching or an enable drops.
- R6: With masterMode=1 the block drives busyOutL and busyOutR. With masterMode=0 both busy outputs stay 0, even during a collision.
- R7: With masterMode=0, memWe of a port is weX AND ceX AND NOT busyInX. An asserted busyIn blocks that port's write strobe.
- R8: With masterMode=1, the write strobe of the port whose busy is 1 is held at 0. The winning port's memWe equals weX AND ceX.
- R9: The winner chosen when a collision starts is kept for the whole collision. This holds even if both addresses then move together to a new common address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1: drive busy outputs; 0: take busy from inputs |
| ceL | input | 1 | Left port enable (active high) |
| ceR | input | 1 | Right port enable (active high) |
| addrL | input | ADDR_W | Left port address |
| addrR | input | ADDR_W | Right port address |
| weL | input | 1 | Left port write request |
| weR | input | 1 | Right port write request |
| busyInL | input | 1 | Left busy from companion arbiter (masterMode=0) |
| busyInR | input | 1 | Right busy from companion arbiter (masterMode=0) |
| busyOutL | output | 1 | Left port must wait |
| busyOutR | output | 1 | Right port must wait |
| memWeL | output | 1 | Gated left write strobe to memory |
| memWeR | output | 1 | Gated right write strobe to memory |

## Verification
The assertions assume that every input is stable around the sampling edge and that masterMode does not change during a collision. The hold property only compares busy against the matching condition when the mode is unchanged. The stimulus changes inputs only at falling edges and samples a nanosecond later. It changes masterMode only while both enables are low. It returns both enables to 0 between scenarios, so each scenario's first cycle has a known previous state.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // datapath -> control: what the ports look like this cycle
  typedef struct packed {
    logic       match;
    logic [1:0] fresh;   // [0] left, [1] right: valid state newly formed this cycle
  } dpStat_t;

  // control -> datapath: which port is blocked this cycle
  typedef struct packed {
    logic [1:0] block;   // [0] left, [1] right
  } ctrlStrobe_t;
endpackage

// File: rtl/dpa_datapath.sv
module dpa_datapath
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic [1:0]        ce,
  input  logic [1:0]        we,
  input  logic [1:0]        busyIn,
  input  logic [ADDR_W-1:0] addr [2],
  input  ctrlStrobe_t       strobe,
  output dpStat_t           stat,
  output logic [1:0]        busyOut,
  output logic [1:0]        memWe
);
  localparam int NPORT = 2;

  logic [1:0] freshV;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic              ceQ;
    logic [ADDR_W-1:0] addrQ;
    logic              blocked;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ceQ   <= 1'b0;
        addrQ <= '0;
      end else begin
        ceQ   <= ce[p];
        addrQ <= addr[p];
      end
    end

    // enabled now, and either just enabled or just moved
    assign freshV[p]  = ce[p] & (~ceQ | (addr[p] != addrQ));
    assign blocked    = masterMode ? strobe.block[p] : busyIn[p];
    assign memWe[p]   = we[p] & ce[p] & ~blocked;
    assign busyOut[p] = masterMode & strobe.block[p];
  end

  assign stat.match = ce[0] & ce[1] & (addr[0] == addr[1]);
  assign stat.fresh = freshV;
endmodule

// File: rtl/dpa_control.sv
module dpa_control
  import dpa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStat_t     stat,
  output ctrlStrobe_t strobe
);
  owner_e ownerQ, ownerNow;

  always_comb begin
    if (!stat.match)
      ownerNow = OWN_NONE;
    else if (ownerQ != OWN_NONE)
      ownerNow = ownerQ;                 // keep the decision for the collision
    else if (stat.fresh[0] && !stat.fresh[1])
      ownerNow = OWN_RIGHT;              // right was there first
    else
      ownerNow = OWN_LEFT;               // left first, or a same-cycle tie
  end

  always_ff @(posedge clk) begin
    if (!rstN) ownerQ <= OWN_NONE;
    else       ownerQ <= ownerNow;
  end

  assign strobe.block[0] = (ownerNow == OWN_RIGHT);
  assign strobe.block[1] = (ownerNow == OWN_LEFT);
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              ceL,
  input  logic              ceR,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              weL,
  input  logic              weR,
  input  logic              busyInL,
  input  logic              busyInR,
  output logic              busyOutL,
  output logic              busyOutR,
  output logic              memWeL,
  output logic              memWeR
);
  dpStat_t           stat;
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] addrV [2];
  logic [1:0]        busyV, weV;

  assign addrV[0] = addrL;
  assign addrV[1] = addrR;

  dpa_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .ce({ceR, ceL}), .we({weR, weL}), .busyIn({busyInR, busyInL}),
    .addr(addrV), .strobe(strobe), .stat(stat),
    .busyOut(busyV), .memWe(weV)
  );

  dpa_control u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .strobe(strobe)
  );

  assign busyOutL = busyV[0];
  assign busyOutR = busyV[1];
  assign memWeL   = weV[0];
  assign memWeR   = weV[1];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterMode,
  input logic              ceL,
  input logic              ceR,
  input logic [ADDR_W-1:0] addrL,
  input logic [ADDR_W-1:0] addrR,
  input logic              busyInL,
  input logic              busyInR,
  input logic              busyOutL,
  input logic              busyOutR,
  input logic              memWeL,
  input logic              memWeR
);
  logic hit;
  assign hit = ceL && ceR && (addrL == addrR);

  AST_BUSY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (busyOutL || busyOutR) |-> hit); // R1

  AST_BUSY_ONE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busyOutL, busyOutR})); // R4

  AST_SLAVE_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (!busyOutL && !busyOutR)); // R6

  AST_SLAVE_BLOCK_L: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && busyInL) |-> !memWeL); // R7

  AST_SLAVE_BLOCK_R: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && busyInR) |-> !memWeR); // R7

  AST_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busyOutL |-> !memWeL) and (busyOutR |-> !memWeR)); // R8

  AST_HOLD_RIGHT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyOutR |=> (!(hit && masterMode) || busyOutR)); // R9

  AST_HOLD_LEFT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyOutL |=> (!(hit && masterMode) || busyOutL)); // R9
endmodule

bind dp_collision_arbiter dpa_checker #(.ADDR_W(ADDR_W)) u_dpa_checker (
  .clk(clk), .rstN(rstN), .masterMode(masterMode),
  .ceL(ceL), .ceR(ceR), .addrL(addrL), .addrR(addrR),
  .busyInL(busyInL), .busyInR(busyInR),
  .busyOutL(busyOutL), .busyOutR(busyOutR),
  .memWeL(memWeL), .memWeR(memWeR)
);

// File: tb/test_dp_collision_arbiter.sv
`timescale 1ns/1ps
module test_dp_collision_arbiter;
  localparam int AW = 16;

  logic clk = 1'b0, rstN = 1'b0, masterMode = 1'b1;
  logic ceL = 0, ceR = 0, weL = 0, weR = 0, busyInL = 0, busyInR = 0;
  logic [AW-1:0] addrL = '0, addrR = '0;
  logic busyOutL, busyOutR, memWeL, memWeR;

  int totalCnt = 0, failCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_collision_arbiter #(.ADDR_W(AW)) i_dp_collision_arbiter (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .ceL(ceL), .ceR(ceR), .addrL(addrL), .addrR(addrR),
    .weL(weL), .weR(weR), .busyInL(busyInL), .busyInR(busyInR),
    .busyOutL(busyOutL), .busyOutR(busyOutR),
    .memWeL(memWeL), .memWeR(memWeR)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // apply inputs just after a falling edge, then settle before sampling
  task automatic drive(logic cl, logic cr, logic [AW-1:0] al, logic [AW-1:0] ar);
    @(negedge clk);
    ceL = cl; ceR = cr; addrL = al; addrR = ar;
    #1;
  endtask

  task automatic idle();
    weL = 0; weR = 0;
    drive(0, 0, 16'h0, 16'h0);
  endtask

  task automatic t_reset();
    chk("R1", "reset busyOutL", busyOutL, 1'b0);
    chk("R1", "reset busyOutR", busyOutR, 1'b0);
    chk("R8", "reset memWeL", memWeL, 1'b0);
  endtask

  task automatic t_no_match();
    drive(1, 1, 16'h0010, 16'h0011);
    chk("R1", "diff addr busyOutL", busyOutL, 1'b0);
    chk("R1", "diff addr busyOutR", busyOutR, 1'b0);
    drive(1, 0, 16'h0011, 16'h0011);
    chk("R1", "one enable busyOutL", busyOutL, 1'b0);
    chk("R1", "one enable busyOutR", busyOutR, 1'b0);
    idle();
  endtask

  task automatic t_ce_arb();
    drive(1, 0, 16'h0123, 16'h0123);
    drive(1, 1, 16'h0123, 16'h0123);
    chk("R2", "left ce first busyOutR", busyOutR, 1'b1);
    chk("R2", "left ce first busyOutL", busyOutL, 1'b0);
    idle();
    drive(0, 1, 16'h0200, 16'h0200);
    drive(1, 1, 16'h0200, 16'h0200);
    chk("R2", "right ce first busyOutL", busyOutL, 1'b1);
    chk("R2", "right ce first busyOutR", busyOutR, 1'b0);
    idle();
  endtask

  task automatic t_addr_arb();
    drive(1, 1, 16'h0001, 16'h0002);
    drive(1, 1, 16'h0001, 16'h0001);
    chk("R3", "right addr moves busyOutR", busyOutR, 1'b1);
    chk("R3", "right addr moves busyOutL", busyOutL, 1'b0);
    drive(1, 1, 16'h0001, 16'h0001);
    chk("R9", "held after a quiet cycle", busyOutR, 1'b1);
    drive(1, 1, 16'h0001, 16'h0003);
    chk("R5", "mismatch releases busyOutR", busyOutR, 1'b0);
    drive(1, 1, 16'h0003, 16'h0003);
    chk("R3", "left addr moves busyOutL", busyOutL, 1'b1);
    chk("R3", "left addr moves busyOutR", busyOutR, 1'b0);
    drive(0, 1, 16'h0003, 16'h0003);
    chk("R5", "enable drop releases busyOutL", busyOutL, 1'b0);
    idle();
  endtask

  task automatic t_tie();
    drive(1, 1, 16'h0044, 16'h0044);
    chk("R4", "tie busyOutR", busyOutR, 1'b1);
    chk("R4", "tie busyOutL", busyOutL, 1'b0);
    idle();
  endtask

  task automatic t_hold();
    // right wins, then both jump together (a fresh tie would favour left)
    drive(0, 1, 16'h0050, 16'h0050);
    drive(1, 1, 16'h0050, 16'h0050);
    chk("R9", "initial winner right busyOutL", busyOutL, 1'b1);
    drive(1, 1, 16'h0060, 16'h0060);
    chk("R9", "joint move keeps busyOutL", busyOutL, 1'b1);
    chk("R9", "joint move busyOutR", busyOutR, 1'b0);
    idle();
  endtask

  task automatic t_master_gate();
    weL = 1; weR = 1;
    drive(1, 0, 16'h0070, 16'h0070);
    chk("R8", "solo left write passes", memWeL, 1'b1);
    chk("R8", "disabled right write", memWeR, 1'b0);
    drive(1, 1, 16'h0070, 16'h0070);
    chk("R8", "loser right write blocked", memWeR, 1'b0);
    chk("R8", "winner left write passes", memWeL, 1'b1);
    idle();
  endtask

  task automatic t_slave();
    @(negedge clk); masterMode = 0;
    weL = 1; weR = 1;
    drive(1, 1, 16'h0080, 16'h0080);
    chk("R6", "slave busyOutL", busyOutL, 1'b0);
    chk("R6", "slave busyOutR", busyOutR, 1'b0);
    chk("R7", "slave no busyIn memWeL", memWeL, 1'b1);
    chk("R7", "slave no busyIn memWeR", memWeR, 1'b1);
    @(negedge clk); busyInL = 1; #1;
    chk("R7", "busyInL blocks memWeL", memWeL, 1'b0);
    chk("R7", "busyInL leaves memWeR", memWeR, 1'b1);
    @(negedge clk); busyInL = 0; busyInR = 1; #1;
    chk("R7", "busyInR blocks memWeR", memWeR, 1'b0);
    chk("R7", "busyInR leaves memWeL", memWeL, 1'b1);
    @(negedge clk); busyInR = 0;
    idle();
    @(negedge clk); masterMode = 1;
    drive(1, 1, 16'h0090, 16'h0090);
    chk("R6", "master drives busyOutR", busyOutR, 1'b1);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rstN = 1;
    t_no_match();
    t_ce_arb();
    t_addr_arb();
    t_tie();
    t_hold();
    t_master_gate();
    t_slave();
    done = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end
endmodule